// File: doc/BRIEF.md
# DAC Register Load Gate with Deferred Update

This block decides when a pending converter code moves from the input holding register into the active output register. A host asks for the transfer with an active-low update strobe. When the transfer request arrives while nothing is busy, the block issues a one-cycle load pulse to the register file straight away.

When the request arrives while the arithmetic datapath is working, the request is not lost. The datapath reports its work through an internal busy flag. Any device sharing the system busy wire can also hold that wire low. In either case the block remembers the request and replays it by itself once busy clears.

The system busy wire is active low and open drain. The block can only pull it low or let it float, and a pull-up provides the high level. A configuration input decides whether the datapath's busy flag is driven onto the wire at all. The internal flag always defers the load, whatever that input says. The update strobe and the sampled busy wire are asynchronous, so each passes through a synchronizer before the block looks for edges in the core clock domain.

Top module: `dac_load_gate`

## Requirements
- R1: With nothing busy, a high-to-low transition on `upd_req_n_i` produces `load_pulse_o` high for one cycle, SYNC_STAGES+1 rising clock edges after the first edge that samples the low level (3 edges with the default of 2).
- R2: A high-to-low transition on `upd_req_n_i` while the effective busy is active produces no load pulse while busy lasts. The load pulse comes on the first rising edge at which the effective busy is seen inactive. Effective busy is true when `busy_int_i` is 1 or the synchronized `busy_line_i` is 0.
- R3: A low level on `busy_line_i` driven by another device defers a request exactly as internal busy does. After the line is released high, the deferred load pulse comes SYNC_STAGES+1 edges later.
- R4: `busy_pull_o` (1 means pull the wire low) equals `busy_int_i` AND `busy_drive_en_i` in the same cycle, with no register in the path. With the drive disabled, a deferred load comes on the first edge after `busy_int_i` falls.
- R5: With the drive enabled, the block's own pull holds the wire low. A deferred load therefore waits until the released wire has passed the synchronizer, which is SYNC_STAGES+1 edges after `busy_int_i` falls.
- R6: Any number of high-to-low transitions on `upd_req_n_i` within one busy period produce exactly one load pulse.
- R7: Every load pulse lasts exactly one cycle, and the stored request is cleared in that same cycle. A later busy period that contains no new transition produces no pulse.
- R8: A low-to-high transition on `upd_req_n_i`, or a level held low, never produces a load pulse.
- R9: While `rst_n` is low, `load_pulse_o` is 0 and no request is stored. Both synchronizers hold the released (high) level, so leaving reset with high inputs produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_req_n_i | input | 1 | Asynchronous active-low update strobe |
| busy_int_i | input | 1 | Datapath busy flag, synchronous, 1 = processing |
| busy_line_i | input | 1 | Sampled level of the open-drain busy wire, asynchronous, 0 = busy |
| busy_drive_en_i | input | 1 | 1 = allow the block to pull the busy wire low |
| busy_pull_o | output | 1 | 1 = enable the open-drain pull-down on the busy wire |
| load_pulse_o | output | 1 | One-cycle strobe that copies the input register into the active register |

## Verification
The hardest situation to reach is a deferred request whose release depends on the block's own drive coming back through the open-drain wire. Internal busy has already dropped, but the wire the block itself pulled low is still seen low for two more synchronizer cycles. The bench models the wire as the AND of the block's pull and an external holder. It releases internal busy with the drive enabled and with the drive disabled, and expects the pulse two cycles apart in the two cases. It also holds the wire low from the external side alone to show that an external hold defers the load in the same way.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;
  typedef enum logic {
    REQ_IDLE  = 1'b0,
    REQ_ARMED = 1'b1
  } req_state_e;
endpackage

// File: rtl/dac_load_sync.sv
module dac_load_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RESET_VAL}};
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dac_load_fall.sv
module dac_load_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;

  // R8: a detected drop never repeats on the next cycle while the level stays low
  a_r8_one_shot_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/dac_load_defer.sv
module dac_load_defer
  import dac_load_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic busy_eff_i,
  output logic load_o
);
  req_state_e state_q, state_d;
  logic       load_q, load_d;
  logic       want;

  assign want = fall_i | (state_q == REQ_ARMED);

  always_comb begin
    load_d  = want & ~busy_eff_i;
    state_d = (want & busy_eff_i) ? REQ_ARMED : REQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= REQ_IDLE;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      load_q  <= load_d;
    end
  end

  assign load_o = load_q;

  // R2: no load is issued on an edge where busy was seen active
  a_r2_no_load_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> !$past(busy_eff_i));

  // R2: a stored request is replayed as soon as busy is seen clear
  a_r2_replay_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == REQ_ARMED && !busy_eff_i) |=> load_q);

  // R1: a drop seen while idle loads on the next edge
  a_r1_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && !busy_eff_i) |=> load_q);

  // R7: the pulse is one cycle wide and leaves nothing stored
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> !load_q);

  a_r7_cleared_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_q) |-> (state_q == REQ_IDLE));
endmodule

// File: rtl/dac_load_gate.sv
module dac_load_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_req_n_i,
  input  logic busy_int_i,
  input  logic busy_line_i,
  input  logic busy_drive_en_i,
  output logic busy_pull_o,
  output logic load_pulse_o
);
  logic upd_s;
  logic line_s;
  logic upd_fall;
  logic busy_eff;

  dac_load_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_upd (
    .clk(clk), .rst_n(rst_n), .d_i(upd_req_n_i), .q_o(upd_s)
  );

  dac_load_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_line (
    .clk(clk), .rst_n(rst_n), .d_i(busy_line_i), .q_o(line_s)
  );

  dac_load_fall u_fall (
    .clk(clk), .rst_n(rst_n), .lvl_i(upd_s), .fall_o(upd_fall)
  );

  assign busy_eff = busy_int_i | ~line_s;

  dac_load_defer u_defer (
    .clk(clk), .rst_n(rst_n), .fall_i(upd_fall), .busy_eff_i(busy_eff),
    .load_o(load_pulse_o)
  );

  assign busy_pull_o = busy_int_i & busy_drive_en_i;

  // R9: nothing is loaded in the first cycle out of reset with idle inputs
  a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n) || $rose(rst_n)) |-> !load_pulse_o);
endmodule

// File: tb/dac_load_gate_bench.sv
module dac_load_gate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_n = 1'b1;
  logic busy_int = 1'b0;
  logic drive_en = 1'b1;
  logic ext_hold = 1'b0;
  logic busy_pull;
  logic load_pulse;
  wire  busy_wire = ~(busy_pull | ext_hold);

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  string cur_req = "R9";
  int   expq[$];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  dac_load_gate u_dac_load_gate (
    .clk(clk), .rst_n(rst_n), .upd_req_n_i(upd_n), .busy_int_i(busy_int),
    .busy_line_i(busy_wire), .busy_drive_en_i(drive_en),
    .busy_pull_o(busy_pull), .load_pulse_o(load_pulse)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_load(input int at);
    expq.push_back(at);
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic check_drained(input string req);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d pulses missing, expected %0d got 0", req, expq.size(), expq.size());
      expq.delete();
    end
  endtask

  // monitor: compares each observed pulse with the scoreboard
  always @(negedge clk) begin
    if (rst_n && load_pulse && !done) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected pulse at cycle %0d, expected none", cur_req, cyc);
      end else begin
        int e;
        e = expq.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL %s: pulse at cycle %0d expected %0d", cur_req, cyc, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    step(2);
    check_bit("R9", load_pulse, 1'b0);
    check_bit("R9", busy_pull, 1'b0);
    rst_n = 1'b1;
    step(5);
    check_drained("R9");

    // R1 and R8: idle request, long low, then release
    cur_req = "R1";
    upd_n = 1'b0; expect_load(cyc + 3);
    step(6);
    cur_req = "R8";
    upd_n = 1'b1;
    step(6);
    check_drained("R1");

    // R2, R5: internal busy with own drive enabled
    cur_req = "R2";
    drive_en = 1'b1; busy_int = 1'b1;
    step(1);
    check_bit("R4", busy_pull, 1'b1);
    step(4);
    upd_n = 1'b0; step(3); upd_n = 1'b1; step(6);
    check_drained("R2");
    cur_req = "R5";
    busy_int = 1'b0; expect_load(cyc + 3);
    step(8);
    check_drained("R5");

    // R4: drive disabled, release loads on next edge
    cur_req = "R4";
    drive_en = 1'b0; busy_int = 1'b1;
    step(1);
    check_bit("R4", busy_pull, 1'b0);
    step(1);
    upd_n = 1'b0; step(3); upd_n = 1'b1; step(5);
    busy_int = 1'b0; expect_load(cyc + 1);
    step(6);
    check_drained("R4");
    drive_en = 1'b1;

    // R6: several requests in one busy period collapse to one
    cur_req = "R6";
    busy_int = 1'b1; step(4);
    for (int k = 0; k < 3; k++) begin
      upd_n = 1'b0; step(3); upd_n = 1'b1; step(4);
    end
    busy_int = 1'b0; expect_load(cyc + 3);
    step(10);
    check_drained("R6");

    // R7: later busy period without a new request gives nothing
    cur_req = "R7";
    busy_int = 1'b1; step(6); busy_int = 1'b0; step(8);
    check_drained("R7");

    // R3: external device holds the wire low
    cur_req = "R3";
    ext_hold = 1'b1; step(4);
    check_bit("R3", busy_pull, 1'b0);
    upd_n = 1'b0; step(3); upd_n = 1'b1; step(6);
    check_drained("R3");
    ext_hold = 1'b0; expect_load(cyc + 3);
    step(8);
    check_drained("R3");

    // R1: request with every source idle after all of the above
    cur_req = "R1";
    upd_n = 1'b0; expect_load(cyc + 3);
    step(3); upd_n = 1'b1; step(6);
    check_drained("R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule